// File: doc/BRIEF.md
# Prioritized Interrupt Request Resolver

This block keeps a 32-bit mask of pending interrupt lines and, whenever the CPU asks for an evaluation, picks one line to service. Lines are fed in two ways. The first is a set of peripheral condition pairs, each a flag and an enable, which map onto line numbers through a parameter. The second is a direct per-line raise input, used for software traps, illegal-opcode traps, the non-maskable request and any other source.

Selection is layered. The software trap always wins, then the illegal-opcode trap, then the non-maskable request (gated only by the X mask bit). Below those, the maskable lines are gated by the I mask bit and ordered by line number, lowest first. An accepted selection comes out one cycle later as a pulse. The pulse carries the line number, the vector-table read address and which condition-code mask bit the CPU must set. The CPU charges its own fixed entry overhead of 14 cycles per accepted interrupt.

Top module: `irq_resolver`

## Requirements
- R1: Each cycle, a peripheral pair whose flag and enable are both 1 sets the pending bit of its mapped line. The default map sends pairs 0..3 to line 11, pair 4 to line 12, pair 5 to line 15, pair 6 to line 24 and pair 7 to line 20. A mapped line with no active pair is cleared.
- R2: When several pairs share one line, all clears are applied before all sets, so the line stays pending while any one of its pairs is active.
- R3: Line 27 (software trap) has top priority and line 28 (illegal opcode) comes next. Neither is masked by X or I, and each clears its own pending bit when accepted.
- R4: Line 26 (non-maskable request) is accepted only when the X mask input is 0, and its pending bit clears on acceptance. While it is pending with X at 1, nothing is accepted, even with lower lines pending.
- R5: With the I mask input at 1, no line other than 26, 27 or 28 is accepted.
- R6: Among the remaining lines, the lowest-numbered pending one is accepted. Its pending bit is not cleared by acceptance.
- R7: The vector address is the base plus twice the line number. The base is 0xFFC0 with boot mode 0 and 0xBFC0 with boot mode 1.
- R8: On acceptance of line 26 the X-set output is 1 and the I-set output is 0. For any other line it is the reverse.
- R9: A raise input bit sets the pending bit at the next edge. An evaluation request produces an accept pulse of exactly one cycle, due one cycle later, and no pulse occurs without an evaluation request.
- R10: Synchronous active-low reset clears the pending mask and all accept outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flag_i | input | PAIR_CNT | Peripheral condition flags |
| enable_i | input | PAIR_CNT | Peripheral condition enables |
| raise_i | input | 32 | Direct per-line raise requests |
| mask_x_i | input | 1 | CPU X mask bit |
| mask_i_i | input | 1 | CPU I mask bit |
| boot_i | input | 1 | Selects the boot-mode vector base |
| eval_i | input | 1 | CPU requests an evaluation this cycle |
| pending_o | output | 32 | Current pending mask |
| take_o | output | 1 | One-cycle accept pulse |
| take_id_o | output | 5 | Accepted line number |
| vec_addr_o | output | ADDR_W | Vector-table read address |
| set_x_o | output | 1 | CPU must set the X mask bit |
| set_i_o | output | 1 | CPU must set the I mask bit |

## Verification
Pending bits are registered, so a raise or a pair change shows on the pending output one edge later. The accept pulse, line number, address and mask-set outputs are registered from the evaluation edge, so they show one edge after the evaluation request and drop one edge after that. The bench drives all inputs on the falling edge and samples on the following falling edge. Every check therefore reads state that exactly one rising edge has produced. The sweep covers every ordinary line in both vector modes.

// File: rtl/irq_res_pkg.sv
// Shared constants for the interrupt resolver.
// Assumes a fixed 32-line pending mask; special line numbers set priority.
package irq_res_pkg;
    localparam int LINES = 32;
    localparam int ID_W  = $clog2(LINES);
    localparam logic [ID_W-1:0] ID_NMI = ID_W'(26);
    localparam logic [ID_W-1:0] ID_SWT = ID_W'(27);
    localparam logic [ID_W-1:0] ID_ILL = ID_W'(28);
endpackage

// File: rtl/irq_pend_update.sv
// Pending-mask register. Each cycle it folds the peripheral pairs into their
// mapped lines (clears first, then sets), applies per-line raises, and drops
// the bits the arbiter consumed. Assumes PAIR_MAP holds ID_W-bit line numbers.
module irq_pend_update
    import irq_res_pkg::*;
#(
    parameter int PAIR_CNT = 8,
    parameter logic [PAIR_CNT*ID_W-1:0] PAIR_MAP = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PAIR_CNT-1:0] flag_i,
    input  logic [PAIR_CNT-1:0] enable_i,
    input  logic [LINES-1:0]    raise_i,
    input  logic [LINES-1:0]    consume_i,
    output logic [LINES-1:0]    pending_o
);
    logic [LINES-1:0] set_m;
    logic [LINES-1:0] clr_m;
    logic [LINES-1:0] pend_q;

    // Build the per-line set and clear masks from the peripheral pairs.
    always_comb begin
        set_m = '0;
        clr_m = '0;
        for (int p = 0; p < PAIR_CNT; p++) begin
            if (flag_i[p] && enable_i[p])
                set_m[PAIR_MAP[p*ID_W +: ID_W]] = 1'b1;
            else
                clr_m[PAIR_MAP[p*ID_W +: ID_W]] = 1'b1;
        end
    end

    // Register the pending mask: clears, then consumption, then sets.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr_m & ~consume_i) | set_m | raise_i;
    end

    assign pending_o = pend_q;
endmodule

// File: rtl/irq_arbiter.sv
// Combinational layered arbiter. Order: software trap, illegal opcode,
// non-maskable (X gated, blocks all below while masked), then maskable lines
// lowest number first (I gated). Reports which bit, if any, is consumed.
module irq_arbiter
    import irq_res_pkg::*;
(
    input  logic [LINES-1:0] pending_i,
    input  logic             mask_x_i,
    input  logic             mask_i_i,
    output logic             hit_o,
    output logic [ID_W-1:0]  id_o,
    output logic [LINES-1:0] consume_o
);
    logic             low_hit;
    logic [ID_W-1:0]  low_id;

    // Find the lowest-numbered pending line.
    always_comb begin
        low_hit = 1'b0;
        low_id  = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pending_i[i]) begin
                low_hit = 1'b1;
                low_id  = ID_W'(i);
            end
        end
    end

    // Apply the priority layers and mask gating.
    always_comb begin
        hit_o     = 1'b0;
        id_o      = '0;
        consume_o = '0;
        if (pending_i[ID_SWT]) begin
            hit_o = 1'b1;
            id_o  = ID_SWT;
            consume_o[ID_SWT] = 1'b1;
        end else if (pending_i[ID_ILL]) begin
            hit_o = 1'b1;
            id_o  = ID_ILL;
            consume_o[ID_ILL] = 1'b1;
        end else if (pending_i[ID_NMI]) begin
            if (!mask_x_i) begin
                hit_o = 1'b1;
                id_o  = ID_NMI;
                consume_o[ID_NMI] = 1'b1;
            end
        end else if (!mask_i_i && low_hit) begin
            hit_o = 1'b1;
            id_o  = low_id;
        end
    end
endmodule

// File: rtl/irq_vector_out.sv
// Registered accept stage: turns an evaluated selection into a one-cycle
// pulse with line number, vector address and the mask bit to set.
// Assumes the base addresses are even and leave room for LINES entries.
module irq_vector_out
    import irq_res_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_NORM = 16'hFFC0,
    parameter logic [ADDR_W-1:0] BASE_BOOT = 16'hBFC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  logic              hit_i,
    input  logic [ID_W-1:0]   id_i,
    input  logic              boot_i,
    output logic              take_o,
    output logic [ID_W-1:0]   take_id_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic              set_x_o,
    output logic              set_i_o
);
    logic [ADDR_W-1:0] base;
    logic              fire;

    // Pick the vector base and qualify the selection.
    always_comb begin
        base = boot_i ? BASE_BOOT : BASE_NORM;
        fire = eval_i && hit_i;
    end

    // Capture the accept pulse and its payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o     <= 1'b0;
            take_id_o  <= '0;
            vec_addr_o <= '0;
            set_x_o    <= 1'b0;
            set_i_o    <= 1'b0;
        end else begin
            take_o     <= fire;
            take_id_o  <= fire ? id_i : '0;
            vec_addr_o <= fire ? base + ADDR_W'({id_i, 1'b0}) : '0;
            set_x_o    <= fire && (id_i == ID_NMI);
            set_i_o    <= fire && (id_i != ID_NMI);
        end
    end
endmodule

// File: rtl/irq_resolver.sv
// Top of the interrupt resolver: pending mask, layered arbiter, accept stage.
// Assumes the CPU samples the accept pulse and pushes state on its own.
module irq_resolver
    import irq_res_pkg::*;
#(
    parameter int PAIR_CNT = 8,
    parameter logic [PAIR_CNT*ID_W-1:0] PAIR_MAP =
        {5'd20, 5'd24, 5'd15, 5'd12, 5'd11, 5'd11, 5'd11, 5'd11},
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_NORM = 16'hFFC0,
    parameter logic [ADDR_W-1:0] BASE_BOOT = 16'hBFC0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PAIR_CNT-1:0] flag_i,
    input  logic [PAIR_CNT-1:0] enable_i,
    input  logic [LINES-1:0]    raise_i,
    input  logic                mask_x_i,
    input  logic                mask_i_i,
    input  logic                boot_i,
    input  logic                eval_i,
    output logic [LINES-1:0]    pending_o,
    output logic                take_o,
    output logic [ID_W-1:0]     take_id_o,
    output logic [ADDR_W-1:0]   vec_addr_o,
    output logic                set_x_o,
    output logic                set_i_o
);
    logic             hit;
    logic [ID_W-1:0]  sel_id;
    logic [LINES-1:0] consume;
    logic [LINES-1:0] consume_q;

    // Consumption only happens on an evaluation cycle.
    always_comb consume_q = consume & {LINES{eval_i}};

    irq_pend_update #(.PAIR_CNT(PAIR_CNT), .PAIR_MAP(PAIR_MAP)) u_pend (
        .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .enable_i(enable_i),
        .raise_i(raise_i), .consume_i(consume_q), .pending_o(pending_o)
    );

    irq_arbiter u_arb (
        .pending_i(pending_o), .mask_x_i(mask_x_i), .mask_i_i(mask_i_i),
        .hit_o(hit), .id_o(sel_id), .consume_o(consume)
    );

    irq_vector_out #(.ADDR_W(ADDR_W), .BASE_NORM(BASE_NORM), .BASE_BOOT(BASE_BOOT)) u_out (
        .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .hit_i(hit), .id_i(sel_id),
        .boot_i(boot_i), .take_o(take_o), .take_id_o(take_id_o),
        .vec_addr_o(vec_addr_o), .set_x_o(set_x_o), .set_i_o(set_i_o)
    );
endmodule

// File: rtl/irq_resolver_chk.sv
// Assertion checker for irq_resolver, attached with bind below.
module irq_resolver_chk
    import irq_res_pkg::*;
#(
    parameter int PAIR_CNT = 8,
    parameter logic [PAIR_CNT*ID_W-1:0] PAIR_MAP = '0,
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_NORM = 16'hFFC0,
    parameter logic [ADDR_W-1:0] BASE_BOOT = 16'hBFC0
) (
    input logic                clk,
    input logic                rst_n,
    input logic [PAIR_CNT-1:0] flag_i,
    input logic [PAIR_CNT-1:0] enable_i,
    input logic [LINES-1:0]    raise_i,
    input logic                mask_x_i,
    input logic                mask_i_i,
    input logic                boot_i,
    input logic                eval_i,
    input logic [LINES-1:0]    pending_o,
    input logic                take_o,
    input logic [ID_W-1:0]     take_id_o,
    input logic [ADDR_W-1:0]   vec_addr_o,
    input logic                set_x_o,
    input logic                set_i_o
);
    for (genvar p = 0; p < PAIR_CNT; p++) begin : g_pair
        a_r1_pair_sets: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(flag_i[p] && enable_i[p]))
                |-> pending_o[PAIR_MAP[p*ID_W +: ID_W]]);
    end

    a_r3_swt_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(eval_i) && $past(pending_o[ID_SWT]))
            |-> (take_o && take_id_o == ID_SWT));

    a_r4_nmi_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(eval_i) && $past(mask_x_i) && $past(pending_o[ID_NMI])
            && !$past(pending_o[ID_SWT]) && !$past(pending_o[ID_ILL]))
            |-> !take_o);

    a_r5_i_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && take_id_o != ID_NMI && take_id_o != ID_SWT && take_id_o != ID_ILL)
            |-> !$past(mask_i_i));

    a_r7_vector: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> vec_addr_o == (($past(boot_i) ? BASE_BOOT : BASE_NORM)
                                  + ADDR_W'({take_id_o, 1'b0})));

    a_r8_one_mask: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ((set_x_o != set_i_o) && (set_x_o == (take_id_o == ID_NMI))));

    a_r9_needs_eval: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(eval_i)) |-> !take_o);

    a_r9_no_mask_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (!set_x_o && !set_i_o));
endmodule

bind irq_resolver irq_resolver_chk #(
    .PAIR_CNT(PAIR_CNT), .PAIR_MAP(PAIR_MAP), .ADDR_W(ADDR_W),
    .BASE_NORM(BASE_NORM), .BASE_BOOT(BASE_BOOT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .enable_i(enable_i),
    .raise_i(raise_i), .mask_x_i(mask_x_i), .mask_i_i(mask_i_i),
    .boot_i(boot_i), .eval_i(eval_i), .pending_o(pending_o), .take_o(take_o),
    .take_id_o(take_id_o), .vec_addr_o(vec_addr_o), .set_x_o(set_x_o),
    .set_i_o(set_i_o)
);

// File: tb/irq_resolver_tb.sv
module irq_resolver_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  flag_i, enable_i;
    logic [31:0] raise_i;
    logic        mask_x_i, mask_i_i, boot_i, eval_i;
    logic [31:0] pending_o;
    logic        take_o;
    logic [4:0]  take_id_o;
    logic [15:0] vec_addr_o;
    logic        set_x_o, set_i_o;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .enable_i(enable_i),
        .raise_i(raise_i), .mask_x_i(mask_x_i), .mask_i_i(mask_i_i),
        .boot_i(boot_i), .eval_i(eval_i), .pending_o(pending_o),
        .take_o(take_o), .take_id_o(take_id_o), .vec_addr_o(vec_addr_o),
        .set_x_o(set_x_o), .set_i_o(set_i_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
    endtask

    task automatic raise(input logic [31:0] m);
        raise_i = m;
        step();
        raise_i = '0;
    endtask

    task automatic evaluate();
        eval_i = 1'b1;
        step();
        eval_i = 1'b0;
    endtask

    function automatic bit special(input int id);
        return id == 11 || id == 12 || id == 15 || id == 20 || id == 24 ||
               id == 26 || id == 27 || id == 28;
    endfunction

    function automatic int pair_line(input int p);
        return (p < 4) ? 11 : (p == 4) ? 12 : (p == 5) ? 15 : (p == 6) ? 24 : 20;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; flag_i = '0; enable_i = '0; raise_i = '0;
        mask_x_i = 1'b0; mask_i_i = 1'b0; boot_i = 1'b0; eval_i = 1'b0;
        step(); step();
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 pending", pending_o, 32'h0);
        chk("R10 take", {31'b0, take_o}, 32'h0);

        // R6 R7 R8 R9: sweep every ordinary line in both vector modes
        for (int b = 0; b < 2; b++) begin
            for (int id = 0; id < 32; id++) begin
                if (!special(id)) begin
                    do_reset();
                    boot_i = b[0];
                    raise(32'h1 << id);
                    chk("R9 raise sets", pending_o, 32'h1 << id);
                    step();
                    chk("R9 no eval no take", {31'b0, take_o}, 32'h0);
                    evaluate();
                    chk("R9 take pulse", {31'b0, take_o}, 32'h1);
                    chk("R6 id", {27'b0, take_id_o}, id);
                    chk("R7 address", {16'b0, vec_addr_o},
                        (b ? 32'hBFC0 : 32'hFFC0) + 2 * id);
                    chk("R8 set_i", {30'b0, set_x_o, set_i_o}, 32'h1);
                    chk("R6 stays pending", pending_o, 32'h1 << id);
                    step();
                    chk("R9 pulse ends", {31'b0, take_o}, 32'h0);
                end
            end
        end
        boot_i = 1'b0;

        // R1: each pair alone, enable then flag
        do_reset();
        for (int p = 0; p < 8; p++) begin
            flag_i = 8'h1 << p; enable_i = 8'h0;
            step();
            chk("R1 enable low", pending_o[pair_line(p)], 1'b0);
            enable_i = 8'h1 << p;
            step();
            chk("R1 both set", pending_o[pair_line(p)], 1'b1);
            flag_i = 8'h0;
            step();
            chk("R1 flag cleared", pending_o, 32'h0);
            enable_i = 8'h0;
        end

        // R2: shared line stays pending while any pair is active
        flag_i = 8'b0000_0101; enable_i = 8'b0000_0101;
        step();
        chk("R2 shared set", pending_o, 32'h1 << 11);
        flag_i = 8'b0000_0100;
        step();
        chk("R2 one pair holds", pending_o, 32'h1 << 11);
        flag_i = 8'b0000_0000;
        step();
        chk("R2 all cleared", pending_o, 32'h0);
        enable_i = 8'h0;

        // R3 R4 R8: layered order with traps, non-maskable and line 3
        do_reset();
        raise((32'h1 << 27) | (32'h1 << 28) | (32'h1 << 26) | (32'h1 << 3));
        evaluate();
        chk("R3 swt first", {27'b0, take_id_o}, 27);
        chk("R3 swt cleared", pending_o[27], 1'b0);
        chk("R8 swt sets I", {30'b0, set_x_o, set_i_o}, 32'h1);
        mask_x_i = 1'b1; mask_i_i = 1'b1;
        evaluate();
        chk("R3 ill unmasked", {26'b0, take_o, take_id_o}, 32'h20 | 28);
        chk("R3 ill cleared", pending_o[28], 1'b0);
        mask_x_i = 1'b0;
        evaluate();
        chk("R4 nmi taken", {26'b0, take_o, take_id_o}, 32'h20 | 26);
        chk("R8 nmi sets X", {30'b0, set_x_o, set_i_o}, 32'h2);
        chk("R4 nmi cleared", pending_o, 32'h1 << 3);
        mask_i_i = 1'b0;
        evaluate();
        chk("R6 line 3", {26'b0, take_o, take_id_o}, 32'h20 | 3);

        // R4 R5: masked non-maskable blocks lower lines; I blocks maskable
        do_reset();
        raise((32'h1 << 26) | (32'h1 << 5));
        mask_x_i = 1'b1;
        evaluate();
        chk("R4 masked nmi blocks", {31'b0, take_o}, 32'h0);
        chk("R4 both still pending", pending_o, (32'h1 << 26) | (32'h1 << 5));
        mask_x_i = 1'b0; mask_i_i = 1'b1;
        evaluate();
        chk("R4 nmi ignores I", {26'b0, take_o, take_id_o}, 32'h20 | 26);
        evaluate();
        chk("R5 I blocks", {31'b0, take_o}, 32'h0);
        mask_i_i = 1'b0;
        evaluate();
        chk("R5 I released", {26'b0, take_o, take_id_o}, 32'h20 | 5);

        // R6: lowest number wins, repeatedly
        do_reset();
        raise((32'h1 << 9) | (32'h1 << 3) | (32'h1 << 30));
        evaluate();
        chk("R6 lowest", {27'b0, take_id_o}, 3);
        evaluate();
        chk("R6 lowest again", {27'b0, take_id_o}, 3);

        // R10: reset mid-operation
        do_reset();
        chk("R10 cleared", pending_o, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule